// File: doc/BRIEF.md
# Packed SIMD Saturating Arithmetic Unit

This unit is a single-cycle registered execution stage that treats two 32-bit register operands as packed lanes and applies one lane-wise operation to all lanes at once. The lane width is chosen per operation: four 8-bit lanes, two 16-bit lanes or one 32-bit lane. The unit offers modular and saturating add and subtract in both signed and unsigned forms, a signed rounding halving add, signed and unsigned min and max, byte reversal and bit reversal within each lane, and a Q15 fixed-point multiply on 16-bit lanes.

A dual-product multiply-accumulate shares the same datapath. It adds both signed 16x16 halfword products to a separately supplied 64-bit accumulator and returns the full 64-bit sum. Any lane that clamps on a saturating operation sets a sticky overflow flag. The flag stays set until a clear request arrives. Operations are issued with a valid strobe, and each result appears one clock later on a registered output.

Top module: `simd_sat_alu`

## Requirements
- R1: The result, the output valid flag and the overflow flag are registered. An operation presented with `in_valid` high at a rising edge appears on `res_out` and `out_valid` after that edge. Synchronous reset clears `res_out`, `out_valid` and `ovf_sticky` to zero.
- R2: Lane width select `esz`: 0 gives 8-bit lanes, 1 gives 16-bit lanes, and 2 or 3 give one 32-bit lane. Lane i occupies bits [i*W+W-1 : i*W]. Opcode 0 is a modular add and opcode 1 a modular subtract; neither carries nor borrows across lane boundaries. Every lane-wise opcode drives `res_out[63:32]` to zero.
- R3: Opcodes 2 and 3 are the signed saturating add and subtract. A result above the lane's most positive value clamps to 0111..1, and a result below the most negative value clamps to 1000..0.
- R4: Opcodes 4 and 5 are the unsigned saturating add and subtract. A sum that exceeds the lane clamps to all-ones, and a difference below zero clamps to zero.
- R5: Opcode 6 is the signed rounding halving add. Each lane returns floor((a+b+1)/2) computed exactly, without intermediate overflow.
- R6: Opcodes 7 and 8 give the signed minimum and maximum per lane. Opcodes 9 and 10 give the unsigned minimum and maximum.
- R7: Opcode 11 is a Q15 multiply on each 16-bit halfword, whatever `esz` says. It returns the signed product shifted right arithmetically by 15 and truncated. The product -1.0 x -1.0 (0x8000 x 0x8000) clamps to 0x7FFF and counts as a saturation.
- R8: Opcode 12 returns acc_in + a.h0*b.h0 + a.h1*b.h1 on all 64 bits of `res_out`, with signed halfword products and modulo 2^64 arithmetic.
- R9: Opcode 13 reverses the byte order within each lane; with 8-bit lanes it leaves the operand unchanged. Opcode 14 reverses the bit order within each lane.
- R10: `ovf_sticky` is set after any valid operation in which at least one lane saturates (opcodes 2 to 5 and 11). Otherwise it keeps its value until `ovf_clr` is high at an edge, which clears it. When a clear and a saturation arrive at the same edge, the flag ends up set.
- R11: Opcode 15 yields a zero result. When `in_valid` is low, `out_valid` goes low after the edge and `res_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Opcode (see requirements) |
| esz | input | 2 | Lane width select |
| opa | input | 32 | First packed operand |
| opb | input | 32 | Second packed operand |
| acc_in | input | 64 | Accumulator for the multiply-accumulate |
| ovf_clr | input | 1 | Clear request for the sticky overflow flag |
| res_out | output | 64 | Registered result |
| out_valid | output | 1 | Result valid |
| ovf_sticky | output | 1 | Sticky saturation flag |

## Verification
The sticky flag clear and a fresh lane saturation can land on the same clock edge. The bench provokes this by raising `ovf_clr` together with a saturating unsigned add, and expects the flag to remain set. The next cycle applies a clear with a non-saturating operation and expects the flag to drop. A bench-side flag model runs over every operation of the boundary-value sweep, so each clamp in every lane width is judged against the clear history as well as against the arithmetic result.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_SADD  = 4'd2,
    OP_SSUB  = 4'd3,
    OP_UADD  = 4'd4,
    OP_USUB  = 4'd5,
    OP_RHADD = 4'd6,
    OP_MIN   = 4'd7,
    OP_MAX   = 4'd8,
    OP_MINU  = 4'd9,
    OP_MAXU  = 4'd10,
    OP_QMUL  = 4'd11,
    OP_MAC   = 4'd12,
    OP_BSWAP = 4'd13,
    OP_BREV  = 4'd14,
    OP_RSV   = 4'd15
  } simd_op_e;

  typedef enum logic [1:0] {
    SZ8  = 2'd0,
    SZ16 = 2'd1,
    SZ32 = 2'd2,
    SZX  = 2'd3
  } simd_sz_e;

  localparam int NUM_SIZES = 3;
endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] r,
  output logic         sat
);
  localparam int NB = W / 8;
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] UMAX = {W{1'b1}};

  logic [W:0]   s_sum, s_dif, u_sum, u_dif, h_sum;
  logic         s_lt, u_lt;
  logic [W-1:0] bsw, brv;

  assign s_sum = {a[W-1], a} + {b[W-1], b};
  assign s_dif = {a[W-1], a} - {b[W-1], b};
  assign u_sum = {1'b0, a} + {1'b0, b};
  assign u_dif = {1'b0, a} - {1'b0, b};
  assign h_sum = s_sum + {{W{1'b0}}, 1'b1};
  assign s_lt  = $signed(a) < $signed(b);
  assign u_lt  = a < b;

  always_comb begin
    for (int k = 0; k < NB; k++) bsw[8*k +: 8] = a[W-8-8*k +: 8];
    for (int k = 0; k < W; k++)  brv[k] = a[W-1-k];
  end

  always_comb begin
    r   = '0;
    sat = 1'b0;
    case (op)
      OP_ADD:  r = u_sum[W-1:0];
      OP_SUB:  r = u_dif[W-1:0];
      OP_SADD: begin
        sat = s_sum[W] ^ s_sum[W-1];
        r   = sat ? (s_sum[W] ? SMIN : SMAX) : s_sum[W-1:0];
      end
      OP_SSUB: begin
        sat = s_dif[W] ^ s_dif[W-1];
        r   = sat ? (s_dif[W] ? SMIN : SMAX) : s_dif[W-1:0];
      end
      OP_UADD: begin
        sat = u_sum[W];
        r   = sat ? UMAX : u_sum[W-1:0];
      end
      OP_USUB: begin
        sat = u_dif[W];
        r   = sat ? '0 : u_dif[W-1:0];
      end
      OP_RHADD: r = h_sum[W:1];
      OP_MIN:   r = s_lt ? a : b;
      OP_MAX:   r = s_lt ? b : a;
      OP_MINU:  r = u_lt ? a : b;
      OP_MAXU:  r = u_lt ? b : a;
      OP_BSWAP: r = bsw;
      OP_BREV:  r = brv;
      default:  r = '0;
    endcase
  end
endmodule

// File: rtl/simd_qmac.sv
module simd_qmac #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  input  logic [2*XLEN-1:0] acc,
  output logic [XLEN-1:0]   q_res,
  output logic              q_sat,
  output logic [2*XLEN-1:0] mac
);
  localparam int NH = XLEN / 16;
  localparam int MW = 2 * XLEN;

  logic signed [31:0] prod [NH];
  logic [NH-1:0]      h_ovf;

  for (genvar h = 0; h < NH; h++) begin : g_half
    logic [16:0] tq;
    assign prod[h] = $signed(a[16*h +: 16]) * $signed(b[16*h +: 16]);
    assign tq      = prod[h][31:15];
    assign h_ovf[h] = tq[16] ^ tq[15];
    assign q_res[16*h +: 16] = h_ovf[h] ? 16'h7fff : tq[15:0];
  end

  assign q_sat = |h_ovf;

  always_comb begin
    mac = acc;
    for (int h = 0; h < NH; h++)
      mac = mac + {{(MW-32){prod[h][31]}}, prod[h]};
  end
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [1:0]        esz,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  input  logic [2*XLEN-1:0] acc_in,
  input  logic              ovf_clr,
  output logic [2*XLEN-1:0] res_out,
  output logic              out_valid,
  output logic              ovf_sticky
);
  localparam int MW = 2 * XLEN;

  logic [XLEN-1:0]      lane_res [NUM_SIZES];
  logic [NUM_SIZES-1:0] lane_sat;
  logic [XLEN-1:0]      q_res;
  logic                 q_sat;
  logic [MW-1:0]        mac;
  logic [MW-1:0]        nxt_res;
  logic                 nxt_sat;
  logic [1:0]           sel;

  for (genvar gi = 0; gi < NUM_SIZES; gi++) begin : g_sz
    localparam int W = 8 << gi;
    localparam int N = XLEN / W;
    logic [XLEN-1:0] r_l;
    logic [N-1:0]    s_l;
    for (genvar li = 0; li < N; li++) begin : g_lane
      simd_lane #(.W(W)) u_lane (
        .op (op),
        .a  (opa[li*W +: W]),
        .b  (opb[li*W +: W]),
        .r  (r_l[li*W +: W]),
        .sat(s_l[li])
      );
    end
    assign lane_res[gi] = r_l;
    assign lane_sat[gi] = |s_l;
  end

  simd_qmac #(.XLEN(XLEN)) u_qmac (
    .a    (opa),
    .b    (opb),
    .acc  (acc_in),
    .q_res(q_res),
    .q_sat(q_sat),
    .mac  (mac)
  );

  assign sel = (esz == SZ8) ? 2'd0 : (esz == SZ16) ? 2'd1 : 2'd2;

  always_comb begin
    nxt_res = '0;
    nxt_sat = 1'b0;
    case (op)
      OP_QMUL: begin
        nxt_res = {{XLEN{1'b0}}, q_res};
        nxt_sat = q_sat;
      end
      OP_MAC: nxt_res = mac;
      OP_RSV: nxt_res = '0;
      default: begin
        nxt_res = {{XLEN{1'b0}}, lane_res[sel]};
        nxt_sat = lane_sat[sel];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out    <= '0;
      out_valid  <= 1'b0;
      ovf_sticky <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      if (in_valid) res_out <= nxt_res;
      ovf_sticky <= (ovf_sticky & ~ovf_clr) | (in_valid & nxt_sat);
    end
  end

  // R1: one-cycle registered latency
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R11: idle cycles keep the result
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res_out) && !out_valid));

  // R10: flag holds without a clear
  p_sticky_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (ovf_sticky && !ovf_clr) |=> ovf_sticky);

  // R10: clear with no new operation drops the flag
  p_sticky_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !in_valid) |=> !ovf_sticky);

  // R6: unsigned max never below either operand
  p_umax_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_MAXU && esz == SZ32) |=>
      (res_out[XLEN-1:0] >= $past(opa) && res_out[XLEN-1:0] >= $past(opb)));

  // R7: -1.0 x -1.0 clamps and raises the flag
  p_qsat_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_QMUL && opa == 32'h8000_8000 && opb == 32'h8000_8000) |=>
      (res_out[31:0] == 32'h7fff_7fff && ovf_sticky));

  // R2: lane-wise results leave the upper half zero
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_ADD) |=> (res_out[MW-1:XLEN] == '0));
endmodule

// File: tb/simd_sat_alu_tb_top.sv
`timescale 1ns/1ps
module simd_sat_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  op;
  logic [1:0]  esz;
  logic [31:0] opa, opb;
  logic [63:0] acc_in;
  logic        ovf_clr;
  logic [63:0] res_out;
  logic        out_valid, ovf_sticky;

  int n_tests = 0;
  int n_fail  = 0;
  bit exp_ovf = 1'b0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  simd_sat_alu dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .esz(esz),
    .opa(opa), .opb(opb), .acc_in(acc_in), .ovf_clr(ovf_clr),
    .res_out(res_out), .out_valid(out_valid), .ovf_sticky(ovf_sticky)
  );

  function automatic string tag_of(int o);
    case (o)
      0, 1:   return "R2";
      2, 3:   return "R3";
      4, 5:   return "R4";
      6:      return "R5";
      7, 8, 9, 10: return "R6";
      11:     return "R7";
      12:     return "R8";
      13, 14: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic longint sx(longint x, int w);
    return (x >= (64'sd1 <<< (w-1))) ? x - (64'sd1 <<< w) : x;
  endfunction

  function automatic void lane_model(input int o, input int w, input longint a,
                                     input longint b, output longint r, output bit s);
    longint m, t, smax, smin;
    m = (64'sd1 <<< w) - 1;
    smax = (64'sd1 <<< (w-1)) - 1;
    smin = -(64'sd1 <<< (w-1));
    s = 1'b0;
    r = 0;
    case (o)
      0: r = a + b;
      1: r = a - b;
      2, 3: begin
        t = (o == 2) ? sx(a, w) + sx(b, w) : sx(a, w) - sx(b, w);
        if (t > smax) begin t = smax; s = 1'b1; end
        if (t < smin) begin t = smin; s = 1'b1; end
        r = t;
      end
      4: begin t = a + b; if (t > m) begin t = m; s = 1'b1; end r = t; end
      5: begin t = a - b; if (t < 0) begin t = 0; s = 1'b1; end r = t; end
      6: r = (sx(a, w) + sx(b, w) + 1) >>> 1;
      7: r = (sx(a, w) < sx(b, w)) ? a : b;
      8: r = (sx(a, w) < sx(b, w)) ? b : a;
      9: r = (a < b) ? a : b;
      10: r = (a < b) ? b : a;
      13: for (int k = 0; k < w/8; k++) r = r | (((a >> (8*k)) & 255) << (w - 8 - 8*k));
      14: for (int k = 0; k < w; k++) r = r | (((a >> k) & 1) << (w - 1 - k));
      default: r = 0;
    endcase
    r = r & m;
  endfunction

  function automatic void vec_model(input int o, input int ez, input logic [31:0] a,
                                    input logic [31:0] b, input logic [63:0] acc,
                                    output logic [63:0] r, output bit s);
    int w;
    longint lr, p, t;
    bit ls;
    r = '0;
    s = 1'b0;
    if (o == 11) begin
      for (int h = 0; h < 2; h++) begin
        p = sx(longint'(a[16*h +: 16]), 16) * sx(longint'(b[16*h +: 16]), 16);
        t = p >>> 15;
        if (t > 32767) begin t = 32767; s = 1'b1; end
        r[16*h +: 16] = t[15:0];
      end
    end else if (o == 12) begin
      t = longint'(acc);
      for (int h = 0; h < 2; h++)
        t = t + sx(longint'(a[16*h +: 16]), 16) * sx(longint'(b[16*h +: 16]), 16);
      r = t;
    end else if (o != 15) begin
      w = (ez == 0) ? 8 : (ez == 1) ? 16 : 32;
      for (int l = 0; l < 32/w; l++) begin
        lane_model(o, w, longint'(a[l*w +: 8]) | (w > 8 ? longint'(a[l*w+8 +: 8]) << 8 : 0)
                          | (w > 16 ? longint'(a[l*w+16 +: 16]) << 16 : 0),
                   longint'(b[l*w +: 8]) | (w > 8 ? longint'(b[l*w+8 +: 8]) << 8 : 0)
                          | (w > 16 ? longint'(b[l*w+16 +: 16]) << 16 : 0),
                   lr, ls);
        for (int k = 0; k < w; k++) r[l*w + k] = lr[k];
        s = s | ls;
      end
    end
  endfunction

  function automatic longint bval(int k, int w);
    longint m;
    m = (64'sd1 <<< w) - 1;
    case (k)
      0: return 0;
      1: return 1;
      2: return (64'sd1 <<< (w-1)) - 1;
      3: return 64'sd1 <<< (w-1);
      4: return (64'sd1 <<< (w-1)) + 1;
      5: return m;
      6: return m - 1;
      default: return 64'sh5a3c96e1 & m;
    endcase
  endfunction

  task automatic run_op(input int o, input int ez, input logic [31:0] a,
                        input logic [31:0] b, input logic [63:0] acc, input bit clr);
    logic [63:0] er;
    bit es;
    vec_model(o, ez, a, b, acc, er, es);
    exp_ovf = (exp_ovf & ~clr) | es;
    in_valid = 1'b1; op = 4'(o); esz = 2'(ez);
    opa = a; opb = b; acc_in = acc; ovf_clr = clr;
    @(negedge clk);
    n_tests++;
    if (res_out !== er || out_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL %s op=%0d esz=%0d a=%h b=%h: actual %h/%b expected %h/1",
               tag_of(o), o, ez, a, b, res_out, out_valid, er);
    end
    n_tests++;
    if (ovf_sticky !== exp_ovf) begin
      n_fail++;
      $display("FAIL R10 op=%0d clr=%0d: actual ovf %b expected %b", o, clr, ovf_sticky, exp_ovf);
    end
  endtask

  task automatic idle_check();
    logic [63:0] prev;
    prev = res_out;
    in_valid = 1'b0; ovf_clr = 1'b0;
    opa = ~opa; op = 4'd0;
    @(negedge clk);
    n_tests++;
    if (res_out !== prev || out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 idle: actual %h/%b expected %h/0", res_out, out_valid, prev);
    end
  endtask

  function automatic logic [31:0] pack(int k, int ez, int step);
    int w;
    logic [31:0] v;
    longint bv;
    w = (ez == 0) ? 8 : (ez == 1) ? 16 : 32;
    v = '0;
    for (int l = 0; l < 32/w; l++) begin
      bv = bval((k + step*l) % 8, w);
      for (int q = 0; q < w; q++) v[l*w + q] = bv[q];
    end
    return v;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int lane_ops [13] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 13, 14};
    rst = 1'b1; in_valid = 1'b1; op = 4'd4; esz = 2'd0;
    opa = 32'hffff_ffff; opb = 32'hffff_ffff; acc_in = '0; ovf_clr = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_tests++;
    if (res_out !== 64'd0 || out_valid !== 1'b0 || ovf_sticky !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: actual %h/%b/%b expected 0/0/0", res_out, out_valid, ovf_sticky);
    end
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R9: boundary-value sweep over every lane width
    for (int oi = 0; oi < 13; oi++)
      for (int ez = 0; ez < 3; ez++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            run_op(lane_ops[oi], ez, pack(i, ez, 1), pack(j, ez, 3), 64'd0, (i == 0 && j == 0));

    // R2: size code 3 behaves as 32-bit lanes
    run_op(0, 3, 32'h7fff_ffff, 32'h0000_0001, 64'd0, 1'b0);
    run_op(2, 3, 32'h7fff_ffff, 32'h0000_0001, 64'd0, 1'b1);
    run_op(14, 3, 32'h0000_0001, 32'h0, 64'd0, 1'b1);

    // R7: Q15 multiply sweep with -1.0 x -1.0 corner
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        run_op(11, 1, pack(i, 1, 1), pack(j, 1, 5), 64'd0, 1'b1);
    run_op(11, 0, 32'h8000_8000, 32'h8000_8000, 64'd0, 1'b1);

    // R8: dual-product accumulate
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        run_op(12, 2, pack(i, 1, 1), pack(j, 1, 2),
               {32'(i * 32'h1357_9bdf), 32'(j * 32'h2468_ace1)}, 1'b0);
    run_op(12, 0, 32'h8000_8000, 32'h8000_8000, 64'hffff_ffff_ffff_ffff, 1'b0);

    // R10: clear and saturation on the same edge, then clear alone
    run_op(4, 0, 32'hff00_0000, 32'h0100_0000, 64'd0, 1'b1);
    run_op(4, 0, 32'hff00_0000, 32'h0100_0000, 64'd0, 1'b1);
    run_op(0, 0, 32'h0101_0101, 32'h0101_0101, 64'd0, 1'b0);
    run_op(0, 0, 32'h0101_0101, 32'h0101_0101, 64'd0, 1'b1);

    // R11: reserved opcode and idle hold
    run_op(9, 1, 32'h1234_5678, 32'h8765_4321, 64'd0, 1'b0);
    idle_check();
    run_op(15, 2, 32'hdead_beef, 32'h1234_5678, 64'h1, 1'b0);
    run_op(13, 1, 32'h1122_3344, 32'h0, 64'd0, 1'b0);
    idle_check();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule